// File: doc/BRIEF.md
# Segmented String Block-Copy Engine

This block moves a run of equally sized elements from one region of a 1 MB byte-addressed memory to another. Each side is named by a 16-bit segment and a 16-bit offset, in the style of real-mode addressing. After a start pulse it alternates a read of one element at the source with a write of that element to the destination. Between elements it moves both offsets by the element size, up or down as a direction bit selects. It stops when the loaded element count has been used up.

A host loads the source and destination pairs, the element count, the element size code and the direction, then pulses `start`. The engine drives a single memory port with separate read and write requests, each held until the memory acknowledges it. A one-cycle `done` pulse ends the copy. The offsets and the remaining count stay visible on the outputs afterwards, so a following copy can pick up where this one stopped.

Top module: `strcopy_engine`

## Requirements
- R1: Every memory request carries the physical address (segment × 16 + offset) modulo 2^20: reads use the source segment and current source offset, writes use the destination segment and current destination offset.
- R2: After each completed element both current offsets increase by the element size when `dir` is 0 and decrease by it when `dir` is 1.
- R3: `size_code` 2'b00 selects 1-byte elements, 2'b01 selects 2-byte elements, and 2'b10 or 2'b11 select 4-byte elements; `mem_bytes` shows that byte count (1, 2 or 4) on every request, and element data occupies the low bytes of the 32-bit data buses, lowest address in bits 7:0.
- R4: Exactly `count_in` elements are copied; `cur_count` drops by one at each completed element and is 0 at the end, and each destination element holds the bytes read from the matching source element.
- R5: A start with `count_in` equal to 0 makes no memory request, keeps `busy` low, raises `done` in the cycle after the start edge, and leaves the offsets at their loaded values.
- R6: Offsets wrap modulo 2^16 when stepping, and a physical address sum beyond bit 19 loses its carry.
- R7: For each element the read request is acknowledged before the write request is raised; the two requests are never high together, a request and its address are held until acknowledged, and the written data equals the data returned by that element's read.
- R8: `busy` is high from the cycle after an accepted start with a nonzero count until the last write is acknowledged; `done` is then high for exactly one cycle, and the final offsets and count hold until the next start.
- R9: A `start` pulse while `busy` is high is ignored and does not change the copy in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a copy with the values on the load inputs |
| size_code | input | 2 | Element size select (see R3) |
| dir | input | 1 | 0 steps offsets upward, 1 downward |
| src_seg | input | 16 | Source segment |
| src_off | input | 16 | Initial source offset |
| dst_seg | input | 16 | Destination segment |
| dst_off | input | 16 | Initial destination offset |
| count_in | input | 16 | Number of elements to copy |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_rd_req | output | 1 | Read request |
| mem_wr_req | output | 1 | Write request |
| mem_addr | output | 20 | Physical byte address of the request |
| mem_bytes | output | 3 | Bytes in the requested element |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with the acknowledge |
| mem_ack | input | 1 | Acknowledge of the pending request |
| cur_src_off | output | 16 | Current source offset |
| cur_dst_off | output | 16 | Current destination offset |
| cur_count | output | 16 | Elements still to copy |

## Verification
A wrong offset or segment shows on `mem_addr` at the very next request, one element after the fault at most, so the memory model checks every address against the arithmetic sequence it expects. A stepping or count fault that leaves the addresses right still appears within one cycle on `cur_src_off`, `cur_dst_off` or `cur_count`, and a count off by one changes how many requests are made before `done`. Faults in data capture show on `mem_wdata` at the following write.

// File: rtl/strcopy_pkg.sv
package strcopy_pkg;

  localparam int SEG_W     = 16;
  localparam int OFF_W     = 16;
  localparam int SEG_SHIFT = 4;
  localparam int PA_W      = SEG_W + SEG_SHIFT;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_DONE = 2'd3
  } cp_state_t;

  // segment * 16 + offset, carry out of the top bit dropped
  function automatic logic [PA_W-1:0] form_phys(input logic [SEG_W-1:0] seg,
                                                input logic [OFF_W-1:0] off);
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] disp;
    base = {seg, {SEG_SHIFT{1'b0}}};
    disp = {{(PA_W-OFF_W){1'b0}}, off};
    return base + disp;
  endfunction

  function automatic logic [2:0] elem_bytes(input logic [1:0] code);
    case (code)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // offset after one element, modulo 2^OFF_W
  function automatic logic [OFF_W-1:0] step_off(input logic [OFF_W-1:0] off,
                                                input logic [1:0] code,
                                                input logic down);
    logic [OFF_W-1:0] s;
    s = {{(OFF_W-3){1'b0}}, elem_bytes(code)};
    return down ? (off - s) : (off + s);
  endfunction

endpackage

// File: rtl/strcopy_fsm.sv
module strcopy_fsm
  import strcopy_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic count_is_zero,
  input  logic last_elem,
  input  logic mem_ack,
  output logic accept,
  output logic capture,
  output logic elem_done,
  output logic rd_req,
  output logic wr_req,
  output logic busy,
  output logic done
);

  cp_state_t state_q, state_d;

  assign rd_req    = (state_q == ST_RD);
  assign wr_req    = (state_q == ST_WR);
  assign busy      = rd_req | wr_req;
  assign done      = (state_q == ST_DONE);
  assign accept    = start & ~busy;
  assign capture   = rd_req & mem_ack;
  assign elem_done = wr_req & mem_ack;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (accept) state_d = count_is_zero ? ST_DONE : ST_RD;
        else        state_d = ST_IDLE;
      end
      ST_RD: if (mem_ack) state_d = ST_WR;
      ST_WR: if (mem_ack) state_d = last_elem ? ST_DONE : ST_RD;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/strcopy_ptrs.sv
module strcopy_ptrs
  import strcopy_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             elem_done,
  input  logic [SEG_W-1:0] src_seg_in,
  input  logic [OFF_W-1:0] src_off_in,
  input  logic [SEG_W-1:0] dst_seg_in,
  input  logic [OFF_W-1:0] dst_off_in,
  input  logic [CNT_W-1:0] count_in,
  input  logic [1:0]       size_in,
  input  logic             dir_in,
  output logic [SEG_W-1:0] src_seg_q,
  output logic [SEG_W-1:0] dst_seg_q,
  output logic [OFF_W-1:0] src_off_q,
  output logic [OFF_W-1:0] dst_off_q,
  output logic [CNT_W-1:0] count_q,
  output logic [1:0]       size_q,
  output logic             dir_q,
  output logic             last_elem
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  assign last_elem = (count_q == CNT_ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_seg_q <= '0;
      dst_seg_q <= '0;
      src_off_q <= '0;
      dst_off_q <= '0;
      count_q   <= '0;
      size_q    <= '0;
      dir_q     <= 1'b0;
    end else if (load) begin
      src_seg_q <= src_seg_in;
      dst_seg_q <= dst_seg_in;
      src_off_q <= src_off_in;
      dst_off_q <= dst_off_in;
      count_q   <= count_in;
      size_q    <= size_in;
      dir_q     <= dir_in;
    end else if (elem_done) begin
      src_off_q <= step_off(src_off_q, size_q, dir_q);
      dst_off_q <= step_off(dst_off_q, size_q, dir_q);
      count_q   <= count_q - CNT_ONE;
    end
  end

endmodule

// File: rtl/strcopy_addr.sv
module strcopy_addr
  import strcopy_pkg::*;
(
  input  logic             wr_phase,
  input  logic [SEG_W-1:0] src_seg,
  input  logic [OFF_W-1:0] src_off,
  input  logic [SEG_W-1:0] dst_seg,
  input  logic [OFF_W-1:0] dst_off,
  input  logic [1:0]       size_code,
  output logic [PA_W-1:0]  src_phys,
  output logic [PA_W-1:0]  dst_phys,
  output logic [PA_W-1:0]  mem_addr,
  output logic [2:0]       mem_bytes
);

  assign src_phys  = form_phys(src_seg, src_off);
  assign dst_phys  = form_phys(dst_seg, dst_off);
  assign mem_addr  = wr_phase ? dst_phys : src_phys;
  assign mem_bytes = elem_bytes(size_code);

endmodule

// File: rtl/strcopy_engine.sv
module strcopy_engine
  import strcopy_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        size_code,
  input  logic              dir,
  input  logic [SEG_W-1:0]  src_seg,
  input  logic [OFF_W-1:0]  src_off,
  input  logic [SEG_W-1:0]  dst_seg,
  input  logic [OFF_W-1:0]  dst_off,
  input  logic [CNT_W-1:0]  count_in,
  output logic              busy,
  output logic              done,
  output logic              mem_rd_req,
  output logic              mem_wr_req,
  output logic [PA_W-1:0]   mem_addr,
  output logic [2:0]        mem_bytes,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic [OFF_W-1:0]  cur_src_off,
  output logic [OFF_W-1:0]  cur_dst_off,
  output logic [CNT_W-1:0]  cur_count
);

  // internal events, named for the checker
  logic             accept;
  logic             capture;
  logic             elem_done;
  logic             last_elem;
  logic             count_is_zero;
  logic [SEG_W-1:0] src_seg_q;
  logic [SEG_W-1:0] dst_seg_q;
  logic [1:0]       size_q;
  logic             dir_q;
  logic [PA_W-1:0]  src_phys;
  logic [PA_W-1:0]  dst_phys;
  logic [DATA_W-1:0] data_q;

  assign count_is_zero = (count_in == '0);

  strcopy_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .count_is_zero (count_is_zero),
    .last_elem     (last_elem),
    .mem_ack       (mem_ack),
    .accept        (accept),
    .capture       (capture),
    .elem_done     (elem_done),
    .rd_req        (mem_rd_req),
    .wr_req        (mem_wr_req),
    .busy          (busy),
    .done          (done)
  );

  strcopy_ptrs #(.CNT_W(CNT_W)) u_ptrs (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .elem_done  (elem_done),
    .src_seg_in (src_seg),
    .src_off_in (src_off),
    .dst_seg_in (dst_seg),
    .dst_off_in (dst_off),
    .count_in   (count_in),
    .size_in    (size_code),
    .dir_in     (dir),
    .src_seg_q  (src_seg_q),
    .dst_seg_q  (dst_seg_q),
    .src_off_q  (cur_src_off),
    .dst_off_q  (cur_dst_off),
    .count_q    (cur_count),
    .size_q     (size_q),
    .dir_q      (dir_q),
    .last_elem  (last_elem)
  );

  strcopy_addr u_addr (
    .wr_phase  (mem_wr_req),
    .src_seg   (src_seg_q),
    .src_off   (cur_src_off),
    .dst_seg   (dst_seg_q),
    .dst_off   (cur_dst_off),
    .size_code (size_q),
    .src_phys  (src_phys),
    .dst_phys  (dst_phys),
    .mem_addr  (mem_addr),
    .mem_bytes (mem_bytes)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       data_q <= '0;
    else if (capture) data_q <= mem_rdata;
  end

  assign mem_wdata = data_q;

endmodule

// File: rtl/strcopy_engine_chk.sv
module strcopy_engine_chk #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              rd,
  input logic              wr,
  input logic              ack,
  input logic [19:0]       addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [15:0]       src_off,
  input logic [15:0]       dst_off,
  input logic [CNT_W-1:0]  cnt,
  input logic              accept,
  input logic              elem_done,
  input logic              zero_cnt,
  input logic [2:0]        nbytes,
  input logic              down
);

  logic [15:0] step16;
  assign step16 = {13'd0, nbytes};

  a_r7_one_req: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && wr));

  a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !ack) |=> (rd && $stable(addr)));

  a_r7_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !ack) |=> (wr && $stable(addr) && $stable(wdata)));

  a_r7_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && ack) |=> (wr && (wdata == $past(rdata))));

  a_r4_count_dec: assert property (@(posedge clk) disable iff (!rst_n)
    elem_done |=> (cnt == $past(cnt) - {{(CNT_W-1){1'b0}}, 1'b1}));

  a_r2_src_step: assert property (@(posedge clk) disable iff (!rst_n)
    elem_done |=> (src_off == ($past(down) ? $past(src_off) - $past(step16)
                                           : $past(src_off) + $past(step16))));

  a_r2_dst_step: assert property (@(posedge clk) disable iff (!rst_n)
    elem_done |=> (dst_off == ($past(down) ? $past(dst_off) - $past(step16)
                                           : $past(dst_off) + $past(step16))));

  a_r5_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && zero_cnt) |=> (done && !busy && !rd && !wr));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !elem_done) |=> $stable(cnt));

endmodule

bind strcopy_engine strcopy_engine_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .rd        (mem_rd_req),
  .wr        (mem_wr_req),
  .ack       (mem_ack),
  .addr      (mem_addr),
  .wdata     (mem_wdata),
  .rdata     (mem_rdata),
  .src_off   (cur_src_off),
  .dst_off   (cur_dst_off),
  .cnt       (cur_count),
  .accept    (accept),
  .elem_done (elem_done),
  .zero_cnt  (count_is_zero),
  .nbytes    (mem_bytes),
  .down      (dir_q)
);

// File: tb/strcopy_engine_tb.sv
module strcopy_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  size_code;
  logic        dir;
  logic [15:0] src_seg, src_off, dst_seg, dst_off, count_in;
  logic        busy, done, mem_rd_req, mem_wr_req;
  logic [19:0] mem_addr;
  logic [2:0]  mem_bytes;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        mem_ack;
  logic [15:0] cur_src_off, cur_dst_off, cur_count;

  always #4 clk = ~clk;

  strcopy_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .size_code(size_code), .dir(dir),
    .src_seg(src_seg), .src_off(src_off), .dst_seg(dst_seg), .dst_off(dst_off),
    .count_in(count_in), .busy(busy), .done(done),
    .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_addr(mem_addr),
    .mem_bytes(mem_bytes), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .cur_src_off(cur_src_off), .cur_dst_off(cur_dst_off),
    .cur_count(cur_count)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int b_phys(input int seg, input int off);
    return (seg * 16 + off) & 32'hFFFFF;
  endfunction

  function automatic int b_off(input int off, input int i, input int b, input bit d);
    return (d ? off - i * b : off + i * b) & 32'hFFFF;
  endfunction

  function automatic logic [7:0] init_byte(input int a);
    return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'h5A;
  endfunction

  logic [7:0] mem [int];

  function automatic logic [7:0] rd_byte(input int a);
    if (mem.exists(a)) return mem[a];
    return init_byte(a);
  endfunction

  // expectations shared with the memory model
  int e_ss, e_so, e_ds, e_do, e_b;
  bit e_dir;
  int rd_i, wr_i, acc, lat, waitcnt;
  logic [31:0] last_rd;

  // memory model: answers at falling edges
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
      mem_rdata = '0;
      waitcnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_rd_req || mem_wr_req) begin
      chk(!(mem_rd_req && mem_wr_req), "R7", "both requests", 1, 0);
      if (waitcnt < lat) waitcnt++;
      else begin
        waitcnt = 0;
        acc++;
        chk(mem_bytes == 3'(e_b), "R3", "mem_bytes", mem_bytes, e_b);
        if (mem_rd_req) begin
          chk(mem_addr == 20'(b_phys(e_ss, b_off(e_so, rd_i, e_b, e_dir))), "R1",
              "read address", mem_addr, b_phys(e_ss, b_off(e_so, rd_i, e_b, e_dir)));
          chk(rd_i == wr_i, "R7", "read before previous write", rd_i, wr_i);
          mem_rdata = '0;
          for (int k = 0; k < e_b; k++)
            mem_rdata[8*k +: 8] = rd_byte((mem_addr + k) & 32'hFFFFF);
          last_rd = mem_rdata;
          rd_i++;
        end else begin
          chk(mem_addr == 20'(b_phys(e_ds, b_off(e_do, wr_i, e_b, e_dir))), "R1",
              "write address", mem_addr, b_phys(e_ds, b_off(e_do, wr_i, e_b, e_dir)));
          chk(wr_i == rd_i - 1, "R7", "write after its read", wr_i, rd_i - 1);
          chk(mem_wdata == last_rd, "R7", "write data", mem_wdata, last_rd);
          for (int k = 0; k < e_b; k++)
            mem[(mem_addr + k) & 32'hFFFFF] = mem_wdata[8*k +: 8];
          wr_i++;
        end
        mem_ack = 1'b1;
      end
    end
  end

  task automatic run_copy(input int ss, input int so, input int ds, input int dof,
                          input int cnt, input int code, input bit dr,
                          input int lt, input bit poke);
    int b, n, bad;
    b = (code == 0) ? 1 : (code == 1) ? 2 : 4;
    mem.delete();
    rd_i = 0; wr_i = 0; acc = 0; lat = lt;
    e_ss = ss; e_so = so; e_ds = ds; e_do = dof; e_b = b; e_dir = dr;
    src_seg = 16'(ss); src_off = 16'(so); dst_seg = 16'(ds); dst_off = 16'(dof);
    count_in = 16'(cnt); size_code = 2'(code); dir = dr;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (cnt == 0) begin
      chk(done == 1'b1, "R5", "done after zero-count start", done, 1);
      chk(busy == 1'b0, "R5", "busy on zero count", busy, 0);
      repeat (3) @(negedge clk);
      chk(acc == 0, "R5", "accesses on zero count", acc, 0);
      chk(cur_src_off == 16'(so), "R5", "src offset kept", cur_src_off, so);
      chk(cur_dst_off == 16'(dof), "R5", "dst offset kept", cur_dst_off, dof);
      chk(cur_count == 16'd0, "R5", "count kept zero", cur_count, 0);
      return;
    end
    chk(busy == 1'b1, "R8", "busy after start", busy, 1);
    n = 0;
    while (!done && n < 5000) begin
      if (poke && n == 2) begin
        start = 1'b1; count_in = 16'd7; src_off = 16'h4444; dir = ~dr;
      end else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(done == 1'b1, "R8", "done reached", done, 1);
    chk(busy == 1'b0, "R8", "busy low at done", busy, 0);
    chk(wr_i == cnt, poke ? "R9" : "R4", "elements written", wr_i, cnt);
    chk(rd_i == cnt, "R4", "elements read", rd_i, cnt);
    chk(cur_count == 16'd0, "R4", "final count", cur_count, 0);
    chk(cur_src_off == 16'(b_off(so, cnt, b, dr)), "R2", "final src offset",
        cur_src_off, b_off(so, cnt, b, dr));
    chk(cur_dst_off == 16'(b_off(dof, cnt, b, dr)), "R2", "final dst offset",
        cur_dst_off, b_off(dof, cnt, b, dr));
    bad = 0;
    for (int i = 0; i < cnt; i++)
      for (int k = 0; k < b; k++)
        if (rd_byte((b_phys(ds, b_off(dof, i, b, dr)) + k) & 32'hFFFFF) !=
            init_byte((b_phys(ss, b_off(so, i, b, dr)) + k) & 32'hFFFFF)) bad++;
    chk(bad == 0, "R4", "destination bytes wrong", bad, 0);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done one cycle only", done, 0);
    repeat (3) @(negedge clk);
    chk(cur_count == 16'd0 && cur_src_off == 16'(b_off(so, cnt, b, dr)), "R8",
        "final values held", cur_src_off, b_off(so, cnt, b, dr));
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; size_code = 2'b00; dir = 1'b0;
    src_seg = '0; src_off = '0; dst_seg = '0; dst_off = '0; count_in = '0;
    lat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_rd_req && !mem_wr_req, "R8", "reset outputs idle",
        {busy, done, mem_rd_req, mem_wr_req}, 0);
    chk(cur_count == 16'd0, "R4", "reset count", cur_count, 0);

    // sweep: R1 R2 R3 R4 over size, direction, count, latency
    for (int code = 0; code < 4; code++)
      for (int d = 0; d < 2; d++)
        for (int c = 1; c <= 5; c += 2)
          for (int l = 0; l < 3; l += 2)
            run_copy(16'h1234, 16'h0100, 16'h5000, 16'h0800, c, code, d[0], l, 1'b0);

    // R5: zero count
    run_copy(16'h1000, 16'h0020, 16'h2000, 16'h0040, 0, 2, 1'b0, 0, 1'b0);
    run_copy(16'h1000, 16'h0020, 16'h2000, 16'h0040, 0, 0, 1'b1, 1, 1'b0);
    // R6: offset wraps upward and downward, physical carry dropped
    run_copy(16'h2000, 16'hFFFE, 16'h3000, 16'h0000, 3, 2, 1'b0, 0, 1'b0);
    run_copy(16'h2000, 16'h0001, 16'h3000, 16'h0100, 3, 1, 1'b1, 1, 1'b0);
    run_copy(16'h0100, 16'h0000, 16'hFFFF, 16'hFFF0, 6, 1, 1'b0, 0, 1'b0);
    run_copy(16'hFFF0, 16'hFFFF, 16'h0400, 16'h0002, 4, 0, 1'b0, 0, 1'b0);
    // R1: different segment:offset pairs naming the same bytes
    run_copy(16'h0800, 16'h0100, 16'h0810, 16'h0000, 4, 2, 1'b0, 1, 1'b0);
    // R9: start while busy
    run_copy(16'h1111, 16'h0200, 16'h6000, 16'h0300, 5, 1, 1'b0, 1, 1'b1);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule